// File: doc/BRIEF.md
# Two-Entry-Per-Word Colour Lookup Table

This block is a 256-entry colour lookup table that software fills through a 32-bit write port. Each written word carries two 15-bit colours, one per 16-bit half, and so fills two adjacent table entries at once. On the way into storage each colour is widened to 8 bits per channel and packed into the pixel format picked by a 2-bit selector. The scan-out path then needs no arithmetic: an 8-bit pixel index returns a ready-to-use packed pixel one cycle later.

A second read port returns the 32-bit words exactly as they were written, so software can read the table back. The packed storage is computed at write time, so the format selector only affects later writes. Software that changes format must write the whole table again.

Top module: `palette_lut`

## Requirements
- R1: A write of `wr_data` to word address n loads entry 2n from bits 15:0 and entry 2n+1 from bits 31:16. No other entry changes.
- R2: In each 16-bit half, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Bit 15 has no effect on the stored colour. Each 5-bit channel becomes 8 bits by appending three zero bits.
- R3: With `fmt` = 0 at write time, the entry is an 8-bit value, zero-extended to 24 bits. From MSB to LSB it holds red[7:5], green[7:5] and blue[7:6].
- R4: With `fmt` = 1 at write time, the entry is a 15-bit value, zero-extended. From MSB to LSB it holds red[7:3], green[7:3] and blue[7:3].
- R5: With `fmt` = 2 at write time, the entry is a 16-bit value, zero-extended. From MSB to LSB it holds red[7:3], green[7:2] and blue[7:3].
- R6: With `fmt` = 3 at write time, the entry is 24 bits: red in 23:16, green in 15:8 and blue in 7:0.
- R7: `lk_valid` is high exactly in the cycle after a cycle with `lk_req` high. In that cycle `lk_pixel` holds the entry at `lk_idx`. `lk_pixel` holds its value while no lookup is requested. After reset `lk_valid` is low.
- R8: A change of `fmt` leaves every stored entry unchanged. Only later writes use the new format.
- R9: `raw_valid` is high exactly in the cycle after `raw_req`. `raw_data` then holds the full 32-bit word last written to `raw_addr`, bit 15 and bit 31 included. After reset `raw_valid` is low.
- R10: A lookup requested in the same cycle as a write to the same word returns the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Packing format applied to writes (0: 3-3-2, 1: 5-5-5, 2: 5-6-5, 3: 8-8-8) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Word address (entry pair) |
| wr_data | input | 32 | Two 16-bit colours, low half to the even entry |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 8 | Pixel index to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_pixel | output | 24 | Packed pixel, zero-extended |
| raw_req | input | 1 | Raw readback request |
| raw_addr | input | 7 | Word address to read back |
| raw_valid | output | 1 | Readback valid |
| raw_data | output | 32 | Word as written |

## Verification
The bench writes words whose two halves differ and checks that the neighbouring pair stays untouched. A design that swapped the halves, or wrote both halves to one entry, would return the wrong colour at the odd or even index. Each format is driven with channel values whose dropped low bits are non-zero, so a packing that took the wrong slice or the wrong order shows at once. Colours that differ only in bit 15 must give the same pixel but a different readback word. After a format switch, old entries must keep their earlier packing, which catches a design that packs at lookup time. A lookup that collides with a write to the same word must return the old colour, which catches a bypass that forwards write data.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    FMT_RGB332 = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB888 = 2'd3
  } pix_fmt_e;

  localparam int CHAN_IN_W  = 5;
  localparam int COLOR_IN_W = 3 * CHAN_IN_W;
  localparam int HALF_W     = 16;
  localparam int PIX_W      = 24;
endpackage

// File: rtl/palette_packer.sv
module palette_packer
  import palette_pkg::*;
(
  input  logic [COLOR_IN_W-1:0] color,
  input  logic [1:0]            fmt,
  output logic [PIX_W-1:0]      pix
);
  logic [7:0] red8, grn8, blu8;

  // widen each 5-bit channel by appending zeros
  assign red8 = {color[4:0],   3'b000};
  assign grn8 = {color[9:5],   3'b000};
  assign blu8 = {color[14:10], 3'b000};

  always_comb begin
    unique case (pix_fmt_e'(fmt))
      FMT_RGB332: pix = {16'd0, red8[7:5], grn8[7:5], blu8[7:6]};
      FMT_RGB555: pix = {9'd0,  red8[7:3], grn8[7:3], blu8[7:3]};
      FMT_RGB565: pix = {8'd0,  red8[7:3], grn8[7:2], blu8[7:3]};
      default:    pix = {red8, grn8, blu8};
    endcase
  end
endmodule

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read returns the prior content on a collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           fmt,
  input  logic                 wr_en,
  input  logic [IDX_W-2:0]     wr_addr,
  input  logic [2*HALF_W-1:0]  wr_data,
  input  logic                 lk_req,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic                 lk_valid,
  output logic [PIX_W-1:0]     lk_pixel,
  input  logic                 raw_req,
  input  logic [IDX_W-2:0]     raw_addr,
  output logic                 raw_valid,
  output logic [2*HALF_W-1:0]  raw_data
);
  localparam int WORD_AW = IDX_W - 1;
  localparam int NHALF   = 2;

  logic [PIX_W-1:0] bank_q [NHALF];
  logic             odd_sel_q;

  // one packer and one bank per half word: even entries in bank 0, odd in bank 1
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [PIX_W-1:0] packed_pix;

    palette_packer u_pack (
      .color (wr_data[h*HALF_W +: COLOR_IN_W]),
      .fmt   (fmt),
      .pix   (packed_pix)
    );

    palette_ram #(.ADDR_W(WORD_AW), .DATA_W(PIX_W)) u_bank (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (packed_pix),
      .re    (lk_req),
      .raddr (lk_idx[IDX_W-1:1]),
      .rdata (bank_q[h])
    );
  end

  palette_ram #(.ADDR_W(WORD_AW), .DATA_W(2*HALF_W)) u_raw (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (raw_req),
    .raddr (raw_addr),
    .rdata (raw_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid  <= 1'b0;
      raw_valid <= 1'b0;
      odd_sel_q <= 1'b0;
    end else begin
      lk_valid  <= lk_req;
      raw_valid <= raw_req;
      if (lk_req) odd_sel_q <= lk_idx[0];
    end
  end

  assign lk_pixel = odd_sel_q ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/palette_lut_checker.sv
module palette_lut_checker
  import palette_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             lk_req,
  input logic             lk_valid,
  input logic [PIX_W-1:0] lk_pixel,
  input logic             raw_req,
  input logic             raw_valid
);
  // R7
  lk_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid);
  // R7
  lk_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_valid);
  // R7
  lk_pixel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lk_req && lk_valid) |=> $stable(lk_pixel));
  // R9
  raw_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    raw_req |=> raw_valid);
  // R9
  raw_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !raw_req |=> !raw_valid);
endmodule

bind palette_lut palette_lut_checker u_palette_lut_checker (
  .clk       (clk),
  .rst       (rst),
  .lk_req    (lk_req),
  .lk_valid  (lk_valid),
  .lk_pixel  (lk_pixel),
  .raw_req   (raw_req),
  .raw_valid (raw_valid)
);

// File: tb/test_palette_lut.sv
module test_palette_lut;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'd3;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        lk_req = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic        lk_valid;
  logic [23:0] lk_pixel;
  logic        raw_req = 1'b0;
  logic [6:0]  raw_addr = '0;
  logic        raw_valid;
  logic [31:0] raw_data;

  int checks = 0;
  int errors = 0;
  logic [23:0] model [256];
  logic [31:0] raw_model [128];

  always #4 clk = ~clk;

  palette_lut i_palette_lut (
    .clk(clk), .rst(rst), .fmt(fmt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_pixel(lk_pixel),
    .raw_req(raw_req), .raw_addr(raw_addr), .raw_valid(raw_valid), .raw_data(raw_data)
  );

  function automatic logic [23:0] expect_pix(input logic [15:0] c, input logic [1:0] f);
    logic [7:0] r, g, b;
    r = {c[4:0], 3'b0};
    g = {c[9:5], 3'b0};
    b = {c[14:10], 3'b0};
    case (f)
      2'd0:    return {16'd0, r[7:5], g[7:5], b[7:6]};
      2'd1:    return {9'd0, r[7:3], g[7:3], b[7:3]};
      2'd2:    return {8'd0, r[7:3], g[7:2], b[7:3]};
      default: return {r, g, b};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[{a, 1'b0}] = expect_pix(d[15:0], fmt);
    model[{a, 1'b1}] = expect_pix(d[31:16], fmt);
    raw_model[a] = d;
  endtask

  task automatic lookup_check(input logic [7:0] idx, input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_idx = idx;
    @(negedge clk);
    lk_req = 1'b0;
    check(lk_valid === 1'b1, "R7", {31'd0, lk_valid}, 32'd1);
    check(lk_pixel === model[idx], req, {8'd0, lk_pixel}, {8'd0, model[idx]});
  endtask

  task automatic t_reset;
    check(lk_valid === 1'b0, "R7", {31'd0, lk_valid}, 32'd0);
    check(raw_valid === 1'b0, "R9", {31'd0, raw_valid}, 32'd0);
  endtask

  task automatic t_pair_mapping; // R1
    fmt = 2'd3;
    write_word(7'd6, 32'h1111_2222);
    write_word(7'd5, 32'h7C1F_03E0);
    lookup_check(8'd10, "R1");
    lookup_check(8'd11, "R1");
    lookup_check(8'd12, "R1");
    lookup_check(8'd13, "R1");
  endtask

  task automatic t_fields; // R2
    fmt = 2'd3;
    write_word(7'd20, 32'h8421_0421);
    lookup_check(8'd40, "R2");
    lookup_check(8'd41, "R2");
    check(model[40] == model[41], "R2", {8'd0, model[40]}, {8'd0, model[41]});
    @(negedge clk);
    lk_req = 1'b1; lk_idx = 8'd41;
    @(negedge clk);
    lk_req = 1'b0;
    check(lk_pixel === 24'h080808, "R2", {8'd0, lk_pixel}, 32'h0008_0808);
    @(negedge clk);
    check(lk_valid === 1'b0, "R7", {31'd0, lk_valid}, 32'd0);
    check(lk_pixel === 24'h080808, "R7", {8'd0, lk_pixel}, 32'h0008_0808);
  endtask

  task automatic t_formats; // R3 R4 R5 R6
    logic [31:0] pat [4];
    pat[0] = 32'h5A5A_A5A5;
    pat[1] = 32'h7FFF_0001;
    pat[2] = 32'h3DEF_4210;
    pat[3] = 32'h1234_6B5D;
    for (int f = 0; f < 4; f++) begin
      fmt = 2'(f);
      for (int k = 0; k < 4; k++) write_word(7'(32 + 4*f + k), pat[k]);
      for (int k = 0; k < 8; k++)
        lookup_check(8'(64 + 8*f + k), f == 0 ? "R3" : f == 1 ? "R4" : f == 2 ? "R5" : "R6");
    end
  endtask

  task automatic t_fmt_change; // R8
    fmt = 2'd3;
    write_word(7'd60, 32'h03E0_7C1F);
    fmt = 2'd0;
    lookup_check(8'd120, "R8");
    lookup_check(8'd121, "R8");
    fmt = 2'd2;
    lookup_check(8'd64, "R8");
  endtask

  task automatic t_raw; // R9
    for (int a = 0; a < 3; a++) begin
      @(negedge clk);
      raw_req = 1'b1; raw_addr = (a == 0) ? 7'd20 : (a == 1) ? 7'd5 : 7'd33;
      @(negedge clk);
      raw_req = 1'b0;
      check(raw_valid === 1'b1, "R9", {31'd0, raw_valid}, 32'd1);
      check(raw_data === raw_model[raw_addr], "R9", raw_data, raw_model[raw_addr]);
    end
    @(negedge clk);
    check(raw_valid === 1'b0, "R9", {31'd0, raw_valid}, 32'd0);
  endtask

  task automatic t_collision; // R10
    logic [23:0] old_val;
    fmt = 2'd3;
    write_word(7'd70, 32'h0000_7FFF);
    old_val = model[140];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'd70; wr_data = 32'h0000_0000;
    lk_req = 1'b1; lk_idx = 8'd140;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    model[140] = 24'h0; model[141] = 24'h0; raw_model[70] = 32'h0;
    check(lk_pixel === old_val, "R10", {8'd0, lk_pixel}, {8'd0, old_val});
    lookup_check(8'd140, "R10");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pair_mapping();
    t_fields();
    t_formats();
    t_fmt_change();
    t_raw();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule